// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Slave

This block is the serial front end of a bank of four digitally stepped potentiometers. It runs on a system clock. It oversamples the two lines of a two-wire serial bus, finds start and stop conditions, and accepts a slave address made of a fixed type code and four strapped address bits. It then decodes a one-byte instruction. The instruction carries an opcode, a data-register select and a pot select. The block then does one of four things: ends the command, takes in a 6-bit data byte, returns one, or enters a streaming mode. In streaming mode every SCL pulse becomes a wiper step, up or down.

The register bank that holds the wiper and stored values sits outside this block. The slave sends that bank a one-cycle command strobe with the decoded fields, or a step strobe with a direction. The bank returns read data for the selected register. The bank also raises a busy flag while a nonvolatile store is in progress. While that flag is high, the slave refuses to acknowledge its address, so the bus master can poll until the store completes. The slave pulls SDA low through an open-drain enable output.

Top module: `dpot_cmd_slave`

## Requirements
- R1: The slave responds only after a start (SDA falling while SCL is high). A stop (SDA rising while SCL is high) returns it to idle, and bytes clocked outside a transaction are never acknowledged.
- R2: The address byte must equal {4'b0101, dev_addr_i}, MSB first, for the slave to acknowledge. On a mismatch the slave gives no acknowledge and ignores the rest of the transaction.
- R3: The instruction byte is laid out as opcode in bits 7:4, register select in bits 3:2 and pot select in bits 1:0. An opcode outside the defined set is not acknowledged, and the slave goes idle.
- R4: The transfer opcodes are 1101, 1110, 0001 and 1000. They are acknowledged and then raise cmd_valid_o for one cycle with the opcode, register and pot fields, with no data byte.
- R5: The write opcodes are 1010 (wiper) and 1100 (data register). They take a third byte that the slave acknowledges. Then cmd_valid_o pulses, with cmd_data_o equal to the low 6 bits of that byte.
- R6: The read opcodes are 1001 (wiper) and 1011 (data register). For these the slave sends {2'b00, rd_data_i} MSB first and releases SDA for the master's acknowledge clock. It raises no command strobe.
- R7: After opcode 0010 is acknowledged, every SCL high pulse ends with a falling SCL edge and a one-cycle step_o pulse. step_up_o is 1 if SDA was high at the rising edge of that pulse, and 0 if SDA was low. The mode ends at a stop, and the SCL pulse that carries the stop yields no step.
- R8: While nv_busy_i is high, the address byte is not acknowledged. Once it is low, the same address is acknowledged.
- R9: The slave asserts SDA drive only while SCL is low, and holds its data stable through each SCL high phase.
- R10: cmd_valid_o and step_o are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| dev_addr_i | input | ADDR_W | Strapped device address bits |
| nv_busy_i | input | 1 | Bank is running a nonvolatile store |
| rd_data_i | input | DATA_W | Read value for the selected register |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Latched opcode |
| cmd_reg_o | output | 2 | Latched data-register select |
| cmd_pot_o | output | 2 | Latched pot select |
| cmd_data_o | output | DATA_W | Data received from the master |
| step_o | output | 1 | One-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
Every response of the block comes on the third rising clock edge after the bus line changes. The delay is two synchroniser flops and then the state register. The command and step strobes, the acknowledge drive and each read data bit all follow this timing. The bench holds each SCL phase for eight clocks, so it reads the acknowledge or data in the middle of the high phase, and again just before SCL falls, when every response is already settled. Strobes are compared on every clock against a queue of expected events. An early, late, extra or missing pulse is caught at the next drain point.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_INSTR,
      ST_WDATA,
      ST_RDATA,
      ST_STEP
   } st_e;

   typedef enum logic [2:0] {
      K_BAD,
      K_XFER,
      K_WRITE,
      K_READ,
      K_STEP
   } kind_e;

   localparam logic [3:0] OP_RD_WIPER   = 4'b1001;
   localparam logic [3:0] OP_WR_WIPER   = 4'b1010;
   localparam logic [3:0] OP_RD_STORE   = 4'b1011;
   localparam logic [3:0] OP_WR_STORE   = 4'b1100;
   localparam logic [3:0] OP_LOAD_ONE   = 4'b1101;
   localparam logic [3:0] OP_SAVE_ONE   = 4'b1110;
   localparam logic [3:0] OP_LOAD_ALL   = 4'b0001;
   localparam logic [3:0] OP_SAVE_ALL   = 4'b1000;
   localparam logic [3:0] OP_STEP       = 4'b0010;

endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("dpot_bus_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[STAGES-1];
         sda_q <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl   = scl_ff[STAGES-1];
   assign sda_lvl   = sda_ff[STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/dpot_op_decode.sv
module dpot_op_decode
   import dpot_pkg::*;
(
   input  logic [3:0] op,
   output kind_e      kind
);

   always_comb begin
      unique case (op)
         OP_LOAD_ONE, OP_SAVE_ONE,
         OP_LOAD_ALL, OP_SAVE_ALL: kind = K_XFER;
         OP_WR_WIPER, OP_WR_STORE: kind = K_WRITE;
         OP_RD_WIPER, OP_RD_STORE: kind = K_READ;
         OP_STEP:                  kind = K_STEP;
         default:                  kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/dpot_cmd_slave.sv
module dpot_cmd_slave
   import dpot_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4,
   parameter int TYPE_CODE   = 5,
   parameter int DATA_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [ADDR_W-1:0] dev_addr_i,
   input  logic              nv_busy_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              cmd_valid_o,
   output logic [3:0]        cmd_op_o,
   output logic [1:0]        cmd_reg_o,
   output logic [1:0]        cmd_pot_o,
   output logic [DATA_W-1:0] cmd_data_o,
   output logic              step_o,
   output logic              step_up_o
);

   localparam int              BYTE_W    = 8;
   localparam int              TYPE_W    = BYTE_W - ADDR_W;
   localparam int              CNT_W     = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
   localparam logic [TYPE_W-1:0] TYPE_BITS = TYPE_W'(TYPE_CODE);

   generate
      if (ADDR_W < 1 || ADDR_W > 7) begin : g_bad_addr
         $error("dpot_cmd_slave: ADDR_W must lie in 1..7");
      end
      if (DATA_W < 1 || DATA_W > BYTE_W) begin : g_bad_data
         $error("dpot_cmd_slave: DATA_W must lie in 1..8");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_s),
      .sda_lvl   (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   st_e                state;
   kind_e              kind_q;
   kind_e              dec_kind;
   logic [CNT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  shreg;
   logic [BYTE_W-1:0]  tx_q;
   logic [3:0]         op_q;
   logic [1:0]         reg_q;
   logic [1:0]         pot_q;
   logic [DATA_W-1:0]  data_q;
   logic               oe_q;
   logic               cmd_q;
   logic               step_q;
   logic               step_up_q;
   logic               up_lat;
   logic [BYTE_W-1:0]  tx_load;
   logic               addr_hit;

   dpot_op_decode u_dec (
      .op   (shreg[7:4]),
      .kind (dec_kind)
   );

   assign tx_load  = BYTE_W'(rd_data_i);
   assign addr_hit = (shreg == {TYPE_BITS, dev_addr_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= K_BAD;
         bit_cnt   <= '0;
         shreg     <= '0;
         tx_q      <= '0;
         op_q      <= '0;
         reg_q     <= '0;
         pot_q     <= '0;
         data_q    <= '0;
         oe_q      <= 1'b0;
         cmd_q     <= 1'b0;
         step_q    <= 1'b0;
         step_up_q <= 1'b0;
         up_lat    <= 1'b0;
      end else begin
         cmd_q  <= 1'b0;
         step_q <= 1'b0;
         if (stop_det) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else if (state == ST_STEP) begin
            if (scl_rise) up_lat <= sda_s;
            if (scl_fall) begin
               step_q    <= 1'b1;
               step_up_q <= up_lat;
            end
         end else if (state != ST_IDLE) begin
            if (scl_rise) begin
               if (bit_cnt < CNT_BYTE) shreg <= {shreg[BYTE_W-2:0], sda_s};
               bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall) begin
               if (state == ST_RDATA) begin
                  if (bit_cnt < CNT_BYTE) begin
                     tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                     oe_q <= ~tx_q[BYTE_W-2];
                  end else if (bit_cnt == CNT_BYTE) begin
                     oe_q <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else if (bit_cnt == CNT_BYTE) begin
                  unique case (state)
                     ST_ADDR: begin
                        if (addr_hit && !nv_busy_i) oe_q <= 1'b1;
                        else                        state <= ST_IDLE;
                     end
                     ST_INSTR: begin
                        op_q   <= shreg[7:4];
                        reg_q  <= shreg[3:2];
                        pot_q  <= shreg[1:0];
                        kind_q <= dec_kind;
                        if (dec_kind != K_BAD) oe_q <= 1'b1;
                        else                   state <= ST_IDLE;
                     end
                     ST_WDATA: begin
                        data_q <= shreg[DATA_W-1:0];
                        oe_q   <= 1'b1;
                     end
                     default: ;
                  endcase
               end else if (bit_cnt == CNT_ACK) begin
                  oe_q    <= 1'b0;
                  bit_cnt <= '0;
                  unique case (state)
                     ST_ADDR: state <= ST_INSTR;
                     ST_INSTR: begin
                        unique case (kind_q)
                           K_XFER: begin
                              cmd_q <= 1'b1;
                              state <= ST_IDLE;
                           end
                           K_WRITE: state <= ST_WDATA;
                           K_READ: begin
                              state <= ST_RDATA;
                              tx_q  <= tx_load;
                              oe_q  <= ~tx_load[BYTE_W-1];
                           end
                           K_STEP: begin
                              state  <= ST_STEP;
                              up_lat <= 1'b0;
                           end
                           default: state <= ST_IDLE;
                        endcase
                     end
                     ST_WDATA: begin
                        cmd_q <= 1'b1;
                        state <= ST_IDLE;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign cmd_valid_o = cmd_q;
   assign cmd_op_o    = op_q;
   assign cmd_reg_o   = reg_q;
   assign cmd_pot_o   = pot_q;
   assign cmd_data_o  = data_q;
   assign step_o      = step_q;
   assign step_up_o   = step_up_q;

endmodule

// File: rtl/dpot_cmd_slave_chk.sv
module dpot_cmd_slave_chk
   import dpot_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input st_e        state,
   input logic       scl_s,
   input logic       nv_busy_i,
   input logic       sda_oe_o,
   input logic       cmd_valid_o,
   input logic [3:0] cmd_op_o,
   input logic       step_o
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o); // R1

   AST_OE_RISES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_s)); // R9

   AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && $rose(sda_oe_o)) |-> !$past(nv_busy_i)); // R8

   AST_STEP_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> (cmd_op_o == OP_STEP)); // R7

   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o); // R10

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid_o && step_o)); // R10

endmodule

bind dpot_cmd_slave dpot_cmd_slave_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .state       (state),
   .scl_s       (scl_s),
   .nv_busy_i   (nv_busy_i),
   .sda_oe_o    (sda_oe_o),
   .cmd_valid_o (cmd_valid_o),
   .cmd_op_o    (cmd_op_o),
   .step_o      (step_o)
);

// File: tb/dpot_cmd_slave_bench.sv
module dpot_cmd_slave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic [3:0] dev_addr = 4'hA;
   logic       busy = 1'b0;
   logic [5:0] rd_data;
   logic       sda_oe, cmd_valid, step, step_up;
   logic [3:0] cmd_op;
   logic [1:0] cmd_reg, cmd_pot;
   logic [5:0] cmd_data;

   int n_vec = 0;
   int n_bad = 0;
   int overlap = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   // bank stub: read value formed from the latched selects
   assign rd_data = {cmd_pot, cmd_reg, cmd_op[1:0]};

   dpot_cmd_slave u_dpot_cmd_slave (
      .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_line),
      .sda_oe_o (sda_oe), .dev_addr_i (dev_addr), .nv_busy_i (busy),
      .rd_data_i (rd_data), .cmd_valid_o (cmd_valid), .cmd_op_o (cmd_op),
      .cmd_reg_o (cmd_reg), .cmd_pot_o (cmd_pot), .cmd_data_o (cmd_data),
      .step_o (step), .step_up_o (step_up)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pk(input bit c, input logic [3:0] op,
      input logic [1:0] r, input logic [1:0] p, input logic [5:0] d, input bit u);
      return {c, op, r, p, d, u};
   endfunction

   // per-clock comparison of strobes against the expected event queue
   always @(negedge clk) begin
      if (rst_n && (cmd_valid || step)) begin
         logic [15:0] got;
         if (cmd_valid && step) overlap++;
         if (cmd_valid)
            got = pk(1'b1, cmd_op, cmd_reg, cmd_pot,
                     (cmd_op == 4'b1010 || cmd_op == 4'b1100) ? cmd_data : 6'd0, 1'b0);
         else
            got = pk(1'b0, cmd_op, cmd_reg, cmd_pot, 6'd0, step_up);
         if (exp_q.size() == 0) chk("R1 unexpected strobe", int'(got), 0);
         else chk(tag_q.pop_front(), int'(got), int'(exp_q.pop_front()));
      end
   end

   task automatic expect_cmd(input string tag, input logic [3:0] op,
      input logic [1:0] r, input logic [1:0] p, input logic [5:0] d);
      exp_q.push_back(pk(1'b1, op, r, p, d, 1'b0));
      tag_q.push_back(tag);
   endtask

   task automatic expect_step(input logic [1:0] p, input bit u);
      exp_q.push_back(pk(1'b0, 4'b0010, 2'b00, p, 6'd0, u));
      tag_q.push_back("R7 step");
   endtask

   task automatic drain(input string tag);
      chk(tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold(Q);
      scl = 1'b1;   hold(Q);
      sda_m = 1'b0; hold(Q);
      scl = 1'b0;   hold(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold(Q);
      scl = 1'b1;   hold(Q);
      sda_m = 1'b1; hold(Q);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b;  hold(Q);
      scl = 1'b1; hold(Q);
      scl = 1'b0; hold(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; hold(Q);
      scl = 1'b1;   hold(Q/2);
      acked = ~sda_line;
      hold(Q/2);
      scl = 1'b0;   hold(Q);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         logic s1;
         sda_m = 1'b1; hold(Q);
         scl = 1'b1;   hold(Q/2);
         s1 = sda_line;
         hold(Q/2 - 1);
         chk("R9 data stable while SCL high", int'(sda_line), int'(s1));
         v[i] = s1;
         hold(1);
         scl = 1'b0;   hold(2);
      end
      send_bit(1'b1);
   endtask

   task automatic open_cmd(input logic [7:0] instr, input bit instr_ack_exp);
      bit a;
      bus_start();
      send_byte({4'b0101, dev_addr}, a);
      chk("R2 address acknowledged", int'(a), 1);
      send_byte(instr, a);
      chk("R3 instruction acknowledge", int'(a), int'(instr_ack_exp));
   endtask

   initial begin : main
      bit a;
      logic [7:0] v;
      logic [3:0] xops [4];
      xops[0] = 4'b1101; xops[1] = 4'b1110; xops[2] = 4'b0001; xops[3] = 4'b1000;

      hold(4);
      chk("R1 reset sda_oe", int'(sda_oe), 0);
      chk("R10 reset cmd_valid", int'(cmd_valid), 0);
      chk("R10 reset step", int'(step), 0);
      rst_n = 1'b1;
      hold(4);

      // R1: bytes without a start get no acknowledge
      send_byte({4'b0101, dev_addr}, a);
      chk("R1 no ack before start", int'(a), 0);
      send_byte(8'hA2, a);
      chk("R1 no ack before start", int'(a), 0);
      bus_stop();
      drain("R1 no strobe before start");

      // R5: write wiper and write store
      open_cmd({4'b1010, 2'b00, 2'b10}, 1'b1);
      expect_cmd("R5 write wiper", 4'b1010, 2'b00, 2'b10, 6'h2B);
      send_byte(8'h2B, a);
      chk("R5 data ack", int'(a), 1);
      bus_stop();
      drain("R5 write wiper strobe");

      open_cmd({4'b1100, 2'b11, 2'b01}, 1'b1);
      expect_cmd("R5 write store low bits", 4'b1100, 2'b11, 2'b01, 6'h3F);
      send_byte(8'hFF, a);
      chk("R5 data ack", int'(a), 1);
      bus_stop();
      drain("R5 write store strobe");

      // R4: all transfer opcodes end after the instruction byte
      for (int k = 0; k < 4; k++) begin
         logic [1:0] r, p;
         r = 2'(k + 1); p = 2'(3 - k);
         expect_cmd("R4 transfer strobe", xops[k], r, p, 6'd0);
         open_cmd({xops[k], r, p}, 1'b1);
         bus_stop();
         drain("R4 transfer drained");
      end

      // R6: reads return {00, pot, reg, op[1:0]} from the bank stub
      open_cmd({4'b1001, 2'b00, 2'b11}, 1'b1);
      recv_byte(v);
      chk("R6 read wiper value", int'(v), 8'b0011_0001);
      chk("R6 released after byte", int'(sda_oe), 0);
      bus_stop();
      open_cmd({4'b1011, 2'b10, 2'b01}, 1'b1);
      recv_byte(v);
      chk("R6 read store value", int'(v), 8'b0001_1011);
      chk("R6 released after byte", int'(sda_oe), 0);
      bus_stop();
      drain("R6 no strobe on read");

      // R7: step stream, stop pulse adds nothing
      open_cmd({4'b0010, 2'b00, 2'b01}, 1'b1);
      begin
         bit pat [5];
         pat[0] = 1; pat[1] = 1; pat[2] = 0; pat[3] = 1; pat[4] = 0;
         for (int k = 0; k < 5; k++) begin
            expect_step(2'b01, pat[k]);
            send_bit(pat[k]);
         end
      end
      bus_stop();
      hold(Q);
      drain("R7 step count");

      // R2: wrong address bits, wrong type code
      bus_start();
      send_byte({4'b0101, 4'hB}, a);
      chk("R2 mismatch no ack", int'(a), 0);
      send_byte({4'b1101, 2'b00, 2'b00}, a);
      chk("R2 rest ignored", int'(a), 0);
      bus_stop();
      bus_start();
      send_byte({4'b0110, dev_addr}, a);
      chk("R2 type code mismatch", int'(a), 0);
      bus_stop();
      drain("R2 no strobe on mismatch");

      // R3: undefined opcode
      open_cmd({4'b0000, 2'b01, 2'b01}, 1'b0);
      send_byte(8'h15, a);
      chk("R3 idle after bad opcode", int'(a), 0);
      bus_stop();
      drain("R3 no strobe on bad opcode");

      // R8: busy withholds address ack
      busy = 1'b1;
      bus_start();
      send_byte({4'b0101, dev_addr}, a);
      chk("R8 no ack while busy", int'(a), 0);
      bus_stop();
      busy = 1'b0;
      expect_cmd("R8 command after busy", 4'b1101, 2'b00, 2'b00, 6'd0);
      open_cmd({4'b1101, 2'b00, 2'b00}, 1'b1);
      bus_stop();
      drain("R8 strobe after busy");

      // R1: repeated start restarts address phase
      bus_start();
      send_byte({4'b0101, dev_addr}, a);
      chk("R1 first address", int'(a), 1);
      expect_cmd("R1 after repeated start", 4'b1110, 2'b10, 2'b10, 6'd0);
      open_cmd({4'b1110, 2'b10, 2'b10}, 1'b1);
      bus_stop();
      drain("R1 repeated start");

      chk("R10 strobes never together", overlap, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule